// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block selects which interrupt cause a 16550-style UART reports to software and drives the single level interrupt line. It holds the 4-bit interrupt enable register, the sticky overrun and break flags of the line status register, and the hidden "transmitter empty" pending flag. The surrounding UART supplies the rest of its state as plain inputs: data-ready, receive FIFO fill count, FIFO enable, trigger-level select, character-timeout pending, transmit-holding-empty level, parity and framing error levels, and the four modem status delta bits.

Register accesses reach the block as one-cycle strobes: an enable register write with its data, a read of the identification register, a read of the line status register, a write to the transmit holding register, and a pulse from the transmitter when the holding register has just emptied. The identification value and the interrupt line are formed combinationally from the registered state and the status inputs, so a strobe registered at one clock edge is visible on the outputs in the cycle after that edge.

Top module: `uart_irq_id`

## Requirements
- R1: After reset ier_o is 0, line_err_o is 0, the transmit-empty pending flag is clear, irq_o is low and iir_o reads 0x01 with the FIFO disabled.
- R2: When several causes are active, the reported cause is the first of: line status, character timeout, receive data, transmit empty, modem status.
- R3: iir_o[3:0] is 0x6 for line status, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending; iir_o[7:6] is 2'b11 while fifo_en_i is high and 2'b00 otherwise; iir_o[5:4] is 0.
- R4: The line status cause is active when enable bit 2 is set and any bit of line_err_o is set; line_err_o is {break, framing, parity, overrun} from bit 3 down to bit 0, with parity and framing following their inputs.
- R5: The character-timeout cause is active when timeout_i is high and enable bit 0 (receive data) is set; it has no enable of its own.
- R6: The receive data cause is active when enable bit 0 and data_ready_i are set and either fifo_en_i is low or rx_count_i is at least the trigger level; trig_sel_i values 0, 1, 2, 3 select levels 1, 4, 8 and 14 for the default depth of 16.
- R7: An enable register write stores ier_wdata_i[3:0] (bit 0 receive data, bit 1 transmit empty, bit 2 line status, bit 3 modem status), ignores bits 7:4, and ier_o shows the stored value from the next cycle.
- R8: An enable register write while thre_i is high sets the transmit-empty pending flag; the transmit-empty cause is active when that flag and enable bit 1 are set.
- R9: thre_set_i sets the pending flag and thr_write_i clears it; when both arrive in one cycle the flag ends up set.
- R10: An identification register read while iir_o[3:0] is 0x2 clears the pending flag; a read while another code is reported leaves it unchanged.
- R11: The modem status cause is active when enable bit 3 is set and any bit of msr_delta_i is set.
- R12: oe_set_i and bi_set_i set the overrun and break flags; a line status read clears both, except that a flag whose set strobe arrives in the same cycle stays set.
- R13: irq_o is high exactly when iir_o[3:0] differs from 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 4 | Stored enable bits |
| fifo_en_i | input | 1 | FIFO mode enabled |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_count_i | input | 5 | Receive FIFO fill count |
| data_ready_i | input | 1 | Receive data ready |
| timeout_i | input | 1 | Character timeout pending |
| oe_set_i | input | 1 | Overrun event strobe |
| bi_set_i | input | 1 | Break event strobe |
| parity_err_i | input | 1 | Parity error level |
| frame_err_i | input | 1 | Framing error level |
| lsr_rd_i | input | 1 | Line status register read strobe |
| line_err_o | output | 4 | {break, framing, parity, overrun} |
| thre_i | input | 1 | Transmit holding register empty level |
| thre_set_i | input | 1 | Transmit holding register just emptied |
| thr_write_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_delta_i | input | 4 | Modem status delta bits |
| iir_o | output | 8 | Interrupt identification value |
| irq_o | output | 1 | Interrupt request level |

## Verification
Changes on the status inputs reach iir_o and irq_o within the same cycle, so the bench changes them on the falling edge and samples one nanosecond later. Every strobe is held across exactly one rising edge and its effect on ier_o, line_err_o, iir_o and irq_o is sampled one nanosecond after the following falling edge, the first point where the updated register is visible. The sweep walks all enable values, both pending states and every input combination with counts 0 to 16 against a priority model computed in the bench; directed sequences cover the strobe collisions.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_MODEM   = 4'h0;
  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_THRE    = 4'h2;
  localparam logic [3:0] ID_RXDATA  = 4'h4;
  localparam logic [3:0] ID_LINE    = 4'h6;
  localparam logic [3:0] ID_TIMEOUT = 4'hC;

  // source index = priority rank, 0 highest
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MODEM   = 4;
  localparam int NSRC        = 5;

  // enable register bit positions
  localparam int IE_RX    = 0;
  localparam int IE_THRE  = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LINE:    src_code = ID_LINE;
      SRC_TIMEOUT: src_code = ID_TIMEOUT;
      SRC_RXDATA:  src_code = ID_RXDATA;
      SRC_THRE:    src_code = ID_THRE;
      default:     src_code = ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] count_i,
  output logic          hit_o
);
  logic [CW-1:0] lvl_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    localparam int L = (g == 0) ? 1 :
                       (g == 1) ? DEPTH / 4 :
                       (g == 2) ? DEPTH / 2 : DEPTH - 2;
    assign lvl_tab[g] = CW'(L);
  end

  assign hit_o = count_i >= lvl_tab[sel_i];
endmodule

// File: rtl/uart_irq_line.sv
module uart_irq_line (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oe_set_i,
  input  logic       bi_set_i,
  input  logic       parity_err_i,
  input  logic       frame_err_i,
  input  logic       rd_i,
  output logic [3:0] err_o
);
  logic oe_q, bi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      // a new event wins over a same-cycle read
      if (oe_set_i)  oe_q <= 1'b1;
      else if (rd_i) oe_q <= 1'b0;
      if (bi_set_i)  bi_q <= 1'b1;
      else if (rd_i) bi_q <= 1'b0;
    end
  end

  assign err_o = {bi_q, frame_err_i, parity_err_i, oe_q};

  AST_LSR_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !oe_set_i && !bi_set_i |=> !err_o[0] && !err_o[3]); // R12
  AST_LSR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_set_i || bi_set_i |=> err_o[0] || err_o[3]); // R12
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ier_i,
  input  logic set_evt_i,
  input  logic clr_wr_i,
  input  logic clr_rd_i,
  output logic pend_o
);
  logic pend_q;
  logic set_any;

  assign set_any = set_ier_i | set_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= 1'b0;
    else if (set_any)               pend_q <= 1'b1;
    else if (clr_wr_i || clr_rd_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_THRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_any |=> pend_o); // R9
  AST_THRE_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rd_i && !set_any |=> !pend_o); // R10
  AST_THRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_any && !clr_wr_i && !clr_rd_i |=> pend_o == $past(pend_o)); // R10
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output logic [3:0]      id_o,
  output logic            irq_o
);
  always_comb begin
    id_o = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = src_code(i);
    end
  end

  assign irq_o = |req_i;
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ier_we_i,
  input  logic [7:0]    ier_wdata_i,
  output logic [3:0]    ier_o,
  input  logic          fifo_en_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic          data_ready_i,
  input  logic          timeout_i,
  input  logic          oe_set_i,
  input  logic          bi_set_i,
  input  logic          parity_err_i,
  input  logic          frame_err_i,
  input  logic          lsr_rd_i,
  output logic [3:0]    line_err_o,
  input  logic          thre_i,
  input  logic          thre_set_i,
  input  logic          thr_write_i,
  input  logic          iir_rd_i,
  input  logic [3:0]    msr_delta_i,
  output logic [7:0]    iir_o,
  output logic          irq_o
);
  logic [3:0]      ier_q;
  logic            rx_hit;
  logic            thre_pend;
  logic [NSRC-1:0] req;
  logic [3:0]      id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_we_i) ier_q <= ier_wdata_i[3:0];
  end

  uart_irq_trig #(.DEPTH(FIFO_DEPTH)) u_trig (
    .sel_i   (trig_sel_i),
    .count_i (rx_count_i),
    .hit_o   (rx_hit)
  );

  uart_irq_line u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oe_set_i     (oe_set_i),
    .bi_set_i     (bi_set_i),
    .parity_err_i (parity_err_i),
    .frame_err_i  (frame_err_i),
    .rd_i         (lsr_rd_i),
    .err_o        (line_err_o)
  );

  uart_irq_thre u_thre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_ier_i (ier_we_i & thre_i),
    .set_evt_i (thre_set_i),
    .clr_wr_i  (thr_write_i),
    .clr_rd_i  (iir_rd_i && id == ID_THRE),
    .pend_o    (thre_pend)
  );

  always_comb begin
    req              = '0;
    req[SRC_LINE]    = ier_q[IE_LINE] && |line_err_o;
    req[SRC_TIMEOUT] = ier_q[IE_RX] && timeout_i;
    req[SRC_RXDATA]  = ier_q[IE_RX] && data_ready_i && (!fifo_en_i || rx_hit);
    req[SRC_THRE]    = ier_q[IE_THRE] && thre_pend;
    req[SRC_MODEM]   = ier_q[IE_MODEM] && |msr_delta_i;
  end

  uart_irq_prio u_prio (
    .req_i (req),
    .id_o  (id),
    .irq_o (irq_o)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, id};
  assign ier_o = ier_q;

  AST_IER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> ier_o == $past(ier_wdata_i[3:0])); // R7
  AST_IER_HI_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i && |ier_wdata_i[7:4] |=> ier_o == $past(ier_wdata_i[3:0])); // R7
  AST_NO_IRQ_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> iir_o[3:0] == ID_NONE); // R13
  AST_LINE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o[IE_LINE] && |line_err_o |-> iir_o[3:0] == ID_LINE); // R2
  AST_RX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_o[IE_RX] |-> iir_o[3:0] != ID_TIMEOUT && iir_o[3:0] != ID_RXDATA); // R5
  AST_UPPER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00 && iir_o[7] == iir_o[6]); // R3
endmodule

// File: tb/uart_irq_id_test.sv
module uart_irq_id_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ier_we_i = 0;
  logic [7:0] ier_wdata_i = 0;
  logic [3:0] ier_o;
  logic       fifo_en_i = 0;
  logic [1:0] trig_sel_i = 0;
  logic [4:0] rx_count_i = 0;
  logic       data_ready_i = 0, timeout_i = 0;
  logic       oe_set_i = 0, bi_set_i = 0, parity_err_i = 0, frame_err_i = 0;
  logic       lsr_rd_i = 0;
  logic [3:0] line_err_o;
  logic       thre_i = 0, thre_set_i = 0, thr_write_i = 0, iir_rd_i = 0;
  logic [3:0] msr_delta_i = 0;
  logic [7:0] iir_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_irq_id uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one strobe across one rising edge; returns 1 ns after the next falling edge
  task automatic settle;
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    @(negedge clk_i);
    ier_we_i = 1; ier_wdata_i = v;
    @(negedge clk_i);
    ier_we_i = 0;
    #1;
  endtask

  function automatic int trig_lvl(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [3:0] model(input logic [3:0] ie, input logic err, input logic to,
                                       input logic dr, input logic fen, input int trg, input int cnt,
                                       input logic pend, input logic md);
    if (ie[2] && err) return 4'h6;
    if (ie[0] && to) return 4'hC;
    if (ie[0] && dr && (!fen || cnt >= trig_lvl(trg))) return 4'h4;
    if (ie[1] && pend) return 4'h2;
    if (ie[3] && md) return 4'h0;
    return 4'h1;
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1 ier", {28'd0, ier_o}, 32'h0);
    chk("R1 iir", {24'd0, iir_o}, 32'h01);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
    chk("R1 err", {28'd0, line_err_o}, 32'h0);

    // R7: upper bits dropped
    wr_ier(8'hFF);
    chk("R7 ier", {28'd0, ier_o}, 32'hF);
    wr_ier(8'hA5);
    chk("R7 ier", {28'd0, ier_o}, 32'h5);

    // R8: enable write with holding register empty sets pending
    thre_i = 1;
    wr_ier(8'h02);
    thre_i = 0;
    chk("R8 iir", {24'd0, iir_o}, 32'h02);
    chk("R13 irq", {31'd0, irq_o}, 32'h1);

    // R10: read while reporting 0x2 clears
    @(negedge clk_i); iir_rd_i = 1; @(negedge clk_i); iir_rd_i = 0; #1;
    chk("R10 clr", {24'd0, iir_o}, 32'h01);
    chk("R13 irq", {31'd0, irq_o}, 32'h0);

    // R10: read while line status reported keeps pending
    wr_ier(8'h06);
    @(negedge clk_i); thre_set_i = 1; parity_err_i = 1; @(negedge clk_i); thre_set_i = 0; #1;
    chk("R4 par", {24'd0, iir_o}, 32'h06);
    @(negedge clk_i); iir_rd_i = 1; @(negedge clk_i); iir_rd_i = 0; parity_err_i = 0; #1;
    chk("R10 keep", {24'd0, iir_o}, 32'h02);

    // R9: write clears; set+write together leaves it set
    @(negedge clk_i); thr_write_i = 1; @(negedge clk_i); thr_write_i = 0; #1;
    chk("R9 clr", {24'd0, iir_o}, 32'h01);
    @(negedge clk_i); thr_write_i = 1; thre_set_i = 1; @(negedge clk_i); thr_write_i = 0; thre_set_i = 0; #1;
    chk("R9 set wins", {24'd0, iir_o}, 32'h02);
    @(negedge clk_i); thr_write_i = 1; @(negedge clk_i); thr_write_i = 0; #1;

    // R12: sticky overrun/break cleared by line status read
    @(negedge clk_i); oe_set_i = 1; @(negedge clk_i); oe_set_i = 0; #1;
    chk("R12 oe", {28'd0, line_err_o}, 32'h1);
    chk("R4 oe", {24'd0, iir_o}, 32'h06);
    @(negedge clk_i); lsr_rd_i = 1; @(negedge clk_i); lsr_rd_i = 0; #1;
    chk("R12 rd", {28'd0, line_err_o}, 32'h0);
    chk("R12 iir", {24'd0, iir_o}, 32'h01);
    @(negedge clk_i); bi_set_i = 1; @(negedge clk_i); bi_set_i = 0; #1;
    chk("R4 brk", {24'd0, iir_o}, 32'h06);
    @(negedge clk_i); bi_set_i = 1; lsr_rd_i = 1; @(negedge clk_i); bi_set_i = 0; lsr_rd_i = 0; #1;
    chk("R12 set wins", {28'd0, line_err_o}, 32'h8);
    @(negedge clk_i); lsr_rd_i = 1; frame_err_i = 1; @(negedge clk_i); lsr_rd_i = 0; #1;
    chk("R12 fe level", {28'd0, line_err_o}, 32'h4);
    chk("R4 fe", {24'd0, iir_o}, 32'h06);
    frame_err_i = 0;

    // sweep: R2 R3 R5 R6 R11 R13
    for (int ie = 0; ie < 16; ie++) begin
      wr_ier(8'(ie));
      for (int p = 0; p < 2; p++) begin
        @(negedge clk_i);
        if (p == 1) thre_set_i = 1; else thr_write_i = 1;
        @(negedge clk_i);
        thre_set_i = 0; thr_write_i = 0;
        for (int er = 0; er < 2; er++)
          for (int to = 0; to < 2; to++)
            for (int dr = 0; dr < 2; dr++)
              for (int fe = 0; fe < 2; fe++)
                for (int tg = 0; tg < 4; tg++)
                  for (int c = 0; c <= 16; c++)
                    for (int md = 0; md < 2; md++) begin
                      @(negedge clk_i);
                      parity_err_i = er[0]; timeout_i = to[0]; data_ready_i = dr[0];
                      fifo_en_i = fe[0]; trig_sel_i = 2'(tg); rx_count_i = 5'(c);
                      msr_delta_i = md[0] ? 4'(1 << (c % 4)) : 4'h0;
                      #1;
                      e = model(4'(ie), er[0], to[0], dr[0], fe[0], tg, c, p[0], md[0]);
                      chk("R2/R3/R6 iir", {24'd0, iir_o}, {24'd0, fe[0], fe[0], 2'b00, e});
                      chk("R13 irq", {31'd0, irq_o}, {31'd0, e != 4'h1});
                    end
        parity_err_i = 0; timeout_i = 0; data_ready_i = 0; fifo_en_i = 0; msr_delta_i = 0;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule